// File: doc/BRIEF.md
# Endpoint-Zero Control and Status Register

This block holds the 8-bit control and status register of a USB device's control endpoint. The CPU side sees a plain register bus: a write strobe with write data, and read data that always reflects the current state. The other side connects to the endpoint-zero transaction engine. The engine reports four events as single-cycle pulses: a packet was received, a packet was transmitted, a STALL handshake went out, or the control transfer ended early. The block gives the engine a STALL request and a FIFO flush strobe, and gives the CPU an interrupt pulse.

Status bits are not cleared by writing them. Two one-shot "serviced" command bits clear the received-packet flag and the early-end flag. A STALL request bit stays set until the engine reports that the handshake went out. When the engine reports an event in the same cycle that software clears the bit, the event wins, so no event is lost.

Top module: `ep0_ctl_reg`

## Requirements
- R1: After reset, every register bit is 0, and rd_data, stall_req, fifo_flush and irq are all low.
- R2: Reads return bit 4 early-end, bit 3 data-end, bit 2 stall-sent, bit 1 tx-ready and bit 0 rx-ready. Bits 7, 6 and 5 always read 0, even right after a 1 is written to them.
- R3: ev_rx_done sets rx-ready. A write with bit 6 = 1 clears it, and writing 0 to bit 0 has no effect. If both happen in the same cycle, rx-ready ends up 1.
- R4: ev_early_end sets early-end only while data-end is 0, and is ignored while data-end is 1. A write with bit 7 = 1 clears early-end. If the event and the clear happen in the same cycle, early-end ends up 1.
- R5: Each event that sets early-end produces a fifo_flush pulse of exactly one cycle, in the cycle after the event.
- R6: A write with bit 5 = 1 raises stall_req. Only ev_stall_sent lowers it, and the same event sets stall-sent. A write with bit 2 = 0 clears stall-sent, and a write with bit 2 = 1 leaves it as it is. If ev_stall_sent and the clear happen in the same cycle, stall-sent ends up 1.
- R7: A write with bit 1 = 1 sets tx-ready, and ev_tx_done clears it. If both happen in the same cycle, the write wins. Writing 0 to bit 1 has no effect.
- R8: A write with bit 3 = 1 sets data-end, and either ev_tx_done or ev_rx_done clears it. If both happen in the same cycle, the write wins. Writing 0 to bit 3 has no effect.
- R9: irq pulses for one cycle, in the cycle after rx-ready or early-end changes from 0 to 1, provided irq_en was high in the event cycle. There is no pulse when irq_en is low, or when the bit was already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| ev_rx_done | input | 1 | Engine pulse: data packet received |
| ev_tx_done | input | 1 | Engine pulse: data packet transmitted |
| ev_stall_sent | input | 1 | Engine pulse: STALL handshake transmitted |
| ev_early_end | input | 1 | Engine pulse: control transfer ended early |
| irq_en | input | 1 | Interrupt enable |
| stall_req | output | 1 | Request to the engine to answer with STALL |
| fifo_flush | output | 1 | One-cycle FIFO flush strobe |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Every result is registered once. A write or an event applied in one cycle therefore shows up in rd_data, stall_req, fifo_flush and irq exactly one clock edge later, and each pulse lasts only that one cycle. The bench drives each step on the falling edge and queues the expected port values for that step. A monitor samples just after the next rising edge and compares them. Because every step has its own entry, a pulse that appears a cycle late, or lasts a cycle too long, shows up as a mismatch on the neighbouring step. The same-cycle conflict cases are driven as single steps, so the priority between them is checked directly.

// File: rtl/ep0_ctl_reg.sv
module ep0_ctl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       ev_rx_done,
  input  logic       ev_tx_done,
  input  logic       ev_stall_sent,
  input  logic       ev_early_end,
  input  logic       irq_en,
  output logic       stall_req,
  output logic       fifo_flush,
  output logic       irq
);
  logic early_end_q, data_end_q, stall_sent_q, tx_rdy_q, rx_rdy_q;
  logic early_set;

  assign early_set = ev_early_end & ~data_end_q;
  assign rd_data   = {3'b000, early_end_q, data_end_q, stall_sent_q, tx_rdy_q, rx_rdy_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      early_end_q  <= 1'b0;
      data_end_q   <= 1'b0;
      stall_sent_q <= 1'b0;
      tx_rdy_q     <= 1'b0;
      rx_rdy_q     <= 1'b0;
      stall_req    <= 1'b0;
      fifo_flush   <= 1'b0;
      irq          <= 1'b0;
    end else begin
      if (early_set)                    early_end_q <= 1'b1;
      else if (wr_en && wr_data[7])     early_end_q <= 1'b0;

      if (ev_rx_done)                   rx_rdy_q <= 1'b1;
      else if (wr_en && wr_data[6])     rx_rdy_q <= 1'b0;

      if (wr_en && wr_data[5])          stall_req <= 1'b1;
      else if (ev_stall_sent)           stall_req <= 1'b0;

      if (ev_stall_sent)                stall_sent_q <= 1'b1;
      else if (wr_en && !wr_data[2])    stall_sent_q <= 1'b0;

      if (wr_en && wr_data[3])          data_end_q <= 1'b1;
      else if (ev_tx_done || ev_rx_done) data_end_q <= 1'b0;

      if (wr_en && wr_data[1])          tx_rdy_q <= 1'b1;
      else if (ev_tx_done)              tx_rdy_q <= 1'b0;

      fifo_flush <= early_set;
      irq        <= irq_en & ((early_set & ~early_end_q) | (ev_rx_done & ~rx_rdy_q));
    end
  end

  assert_rx_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_done |=> rd_data[0]);
  assert_rx_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[6] && !ev_rx_done) |=> !rd_data[0]);
  assert_flush_with_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> rd_data[4]);
  assert_stall_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stall_sent && !(wr_en && wr_data[5])) |=> (!stall_req && rd_data[2]));
  assert_tx_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1]) |=> rd_data[1]);
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en));
endmodule

// File: tb/ep0_ctl_reg_test.sv
module ep0_ctl_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ev_rx_done = 1'b0, ev_tx_done = 1'b0, ev_stall_sent = 1'b0, ev_early_end = 1'b0;
  logic       irq_en = 1'b0;
  logic       stall_req, fifo_flush, irq;

  typedef struct {
    logic [7:0] rd;
    logic       stall;
    logic       flush;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ep0_ctl_reg uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_rx_done(ev_rx_done), .ev_tx_done(ev_tx_done), .ev_stall_sent(ev_stall_sent),
    .ev_early_end(ev_early_end), .irq_en(irq_en), .stall_req(stall_req),
    .fifo_flush(fifo_flush), .irq(irq));

  task automatic step(input logic w, input logic [7:0] d, input logic rx, input logic tx,
                      input logic st, input logic ee, input logic ie,
                      input logic [7:0] e_rd, input logic e_st, input logic e_fl, input logic e_irq,
                      input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = w; wr_data = d; ev_rx_done = rx; ev_tx_done = tx;
    ev_stall_sent = st; ev_early_end = ee; irq_en = ie;
    e.rd = e_rd; e.stall = e_st; e.flush = e_fl; e.irq = e_irq; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (rd_data !== e.rd || stall_req !== e.stall || fifo_flush !== e.flush || irq !== e.irq) begin
        errors++;
        $display("FAIL %s: got rd=%h stall=%b flush=%b irq=%b, expected rd=%h stall=%b flush=%b irq=%b",
                 e.tag, rd_data, stall_req, fifo_flush, irq, e.rd, e.stall, e.flush, e.irq);
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //    w  data  rx tx st ee ie   rd   stl fl irq  tag
    step(0, 8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, "R1 reset state");
    step(0, 8'h00, 1, 0, 0, 0, 1, 8'h01, 0, 0, 1, "R3 R9 rx set with irq");
    step(0, 8'h00, 1, 0, 0, 0, 1, 8'h01, 0, 0, 0, "R9 no irq when already set");
    step(1, 8'h00, 0, 0, 0, 0, 0, 8'h01, 0, 0, 0, "R3 write 0 ignored");
    step(1, 8'h40, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, "R3 serviced clears rx");
    step(1, 8'h40, 1, 0, 0, 0, 0, 8'h01, 0, 0, 0, "R3 R9 set wins, irq disabled");
    step(1, 8'h40, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, "R3 clear again");
    step(0, 8'h00, 0, 0, 0, 1, 1, 8'h10, 0, 1, 1, "R4 R5 R9 early end");
    step(0, 8'h00, 0, 0, 0, 0, 1, 8'h10, 0, 0, 0, "R5 flush one cycle");
    step(1, 8'hE0, 0, 0, 0, 0, 0, 8'h00, 1, 0, 0, "R2 R6 commands read zero, stall raised");
    step(1, 8'h80, 0, 0, 0, 1, 0, 8'h10, 1, 1, 0, "R4 set wins over clear");
    step(1, 8'h80, 0, 0, 0, 0, 0, 8'h00, 1, 0, 0, "R4 R6 clear, stall held");
    step(0, 8'h00, 0, 0, 1, 0, 0, 8'h04, 0, 0, 0, "R6 stall sent");
    step(1, 8'h04, 0, 0, 0, 0, 0, 8'h04, 0, 0, 0, "R6 write 1 keeps sent-stall");
    step(1, 8'h00, 0, 0, 1, 0, 0, 8'h04, 0, 0, 0, "R6 set wins over clear");
    step(1, 8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, "R6 write 0 clears");
    step(1, 8'h0A, 0, 0, 0, 0, 0, 8'h0A, 0, 0, 0, "R7 R8 set tx and data-end");
    step(0, 8'h00, 0, 0, 0, 1, 1, 8'h0A, 0, 0, 0, "R4 early end ignored with data-end");
    step(1, 8'h00, 0, 0, 0, 0, 0, 8'h0A, 0, 0, 0, "R7 R8 write 0 ignored");
    step(0, 8'h00, 0, 1, 0, 0, 0, 8'h00, 0, 0, 0, "R7 R8 tx done clears");
    step(1, 8'h02, 0, 1, 0, 0, 0, 8'h02, 0, 0, 0, "R7 write wins");
    step(0, 8'h00, 0, 1, 0, 0, 0, 8'h00, 0, 0, 0, "R7 cleared");
    step(1, 8'h08, 1, 0, 0, 0, 1, 8'h09, 0, 0, 1, "R8 write wins over rx clear");
    step(1, 8'h40, 0, 0, 0, 0, 0, 8'h08, 0, 0, 0, "R3 R8 rx cleared, data-end held");
    step(0, 8'h00, 1, 0, 0, 0, 0, 8'h01, 0, 0, 0, "R8 rx clears data-end");
    step(1, 8'h40, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, "R3 final clear");
    step(0, 8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, "R1 idle");
    wait (sb.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule